// File: doc/BRIEF.md
# Data Address Access Checker with Fault Capture

This block checks a data virtual address before it is used for memory. It tests that the address is well formed. It recognises a kernel-only direct-mapped window (the superpage) and translates addresses in that window without a lookup. For all other addresses it takes the result of an external page-table lookup and applies that entry's permission bits for the current privilege mode. The output of each request is a fault class, a six-bit status word and, for accesses that pass, a physical address.

When a request faults, the block latches three values: the faulting address, the status word, and a formatted page-table-entry address. It skips this latch when the request is a page-table-entry fetch, is marked no-fault, or is speculative. The earlier captured values then stay in place for the handler. The page-table storage and the lookup itself are outside this block.

Every request produces one registered response one clock later. The capture registers update on that same edge.

Top module: `dtb_access_check`

## Requirements
- R1: After synchronous reset, rsp_valid, rsp_fault, rsp_stat, rsp_pa, cap_va, cap_stat and cap_form are all zero.
- R2: An address is valid only when bits 63:47 are all equal. An invalid address gives fault code 2 (general) and status bad-VA (bit 5) plus access violation (bit 1), plus write (bit 0) on stores. This check takes precedence over all others.
- R3: A valid address with bits 47:41 equal to 0x7E is a superpage access. When the mode is not kernel (mode 0), it gives fault code 1 (access) and status access violation, plus write on stores.
- R4: A kernel superpage access gives fault code 0 and status 0. The 44-bit PA takes address bits 39:0, and PA bits 43:40 are filled with copies of address bit 40.
- R5: A lookup miss (lk_hit low) gives status DTB-miss (bit 4), plus write on stores. The fault code is 4 when the request is a page-table-entry fetch and 3 otherwise.
- R6: A store whose entry write-enable bit for the current mode is clear gives fault code 2 with status write plus access violation, plus fault-on-write (bit 3) when the entry's fault-on-write bit is set. A store that is enabled but has fault-on-write set gives fault code 2 with status write plus fault-on-write.
- R7: A load whose read-enable bit for the mode is clear gives fault code 1 with status access violation, plus fault-on-read (bit 2) when fault-on-read is set. An enabled load with fault-on-read set gives fault code 2 with status fault-on-read. Loads never set the write bit.
- R8: A permitted lookup access gives fault code 0, status 0, and PA = {lk_pfn, address bits 12:0}. Any faulting request returns PA 0.
- R9: On a captured fault, cap_va receives the address and cap_stat receives the status. cap_form receives ptbase OR (address bits 42:13 shifted left by 3).
- R10: The capture registers keep their values when a request does not fault, or when it sets req_pte_fetch, req_no_fault or req_spec.
- R11: rsp_valid is high exactly one cycle after each cycle with req_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Data virtual address |
| req_write | input | 1 | 1 for store, 0 for load |
| req_mode | input | 2 | Privilege mode, 0 is kernel |
| req_pte_fetch | input | 1 | Request is a page-table-entry fetch |
| req_no_fault | input | 1 | Access must not record fault state |
| req_spec | input | 1 | Speculative access |
| lk_hit | input | 1 | Lookup found an entry |
| lk_rd_en | input | 4 | Read enable per mode, bit index is mode |
| lk_wr_en | input | 4 | Write enable per mode, bit index is mode |
| lk_fault_rd | input | 1 | Entry fault-on-read bit |
| lk_fault_wr | input | 1 | Entry fault-on-write bit |
| lk_pfn | input | 31 | Entry page frame number |
| ptbase | input | 64 | Page-table base for the formatted address |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 3 | Fault code: 0 none, 1 access, 2 general, 3 miss, 4 page-table-fetch miss |
| rsp_stat | output | 6 | Status word |
| rsp_pa | output | 44 | Physical address when no fault |
| cap_va | output | 64 | Captured faulting address |
| cap_stat | output | 6 | Captured status word |
| cap_form | output | 64 | Captured formatted entry address |

## Verification
On every cycle the assertions check four things. Each response follows its request by one cycle. Fault code and status agree: a non-zero code always has status bits, and a clean response has none. Miss codes carry the miss bit, and loads never carry the write bit. The capture registers hold still after a fetch, no-fault or speculative request, and a non-kernel superpage access always faults. The exact status compositions depend on specific stimulus, so only the bench's sweeps can show them. The same holds for the superpage physical sign extension, the mode-indexed selection among the permission bits, the choice between the two miss codes and the formatted-address contents.

// File: rtl/dtb_chk_pkg.sv
package dtb_chk_pkg;
  localparam int STAT_W = 6;
  localparam int ST_WR   = 0;
  localparam int ST_ACV  = 1;
  localparam int ST_FOR  = 2;
  localparam int ST_FOW  = 3;
  localparam int ST_MISS = 4;
  localparam int ST_BAD  = 5;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ACCESS   = 3'd1,
    FLT_GENERAL  = 3'd2,
    FLT_MISS     = 3'd3,
    FLT_PTE_MISS = 3'd4
  } flt_e;

  typedef struct packed {
    flt_e              code;
    logic [STAT_W-1:0] stat;
  } verdict_t;
endpackage

// File: rtl/dtb_va_classify.sv
module dtb_va_classify #(
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 48,
  parameter int PA_W    = 44,
  parameter int SP_LO   = 41,
  parameter int SP_TAG  = 'h7E,
  parameter int EXT_BIT = 40
) (
  input  logic [VA_W-1:0] va,
  output logic            va_ok,
  output logic            is_sp,
  output logic [PA_W-1:0] sp_pa
);
  localparam int TOP_W = VA_W - VA_IMPL + 1;
  localparam int SP_W  = VA_IMPL - SP_LO;
  localparam int EXT_W = PA_W - EXT_BIT;

  logic [TOP_W-1:0] top_bits;

  always_comb begin
    top_bits = va[VA_W-1:VA_IMPL-1];
    va_ok    = (&top_bits) | ~(|top_bits);
    is_sp    = va_ok && (va[VA_IMPL-1:SP_LO] == SP_W'(SP_TAG));
    sp_pa    = {{EXT_W{va[EXT_BIT]}}, va[EXT_BIT-1:0]};
  end
endmodule

// File: rtl/dtb_perm_check.sv
module dtb_perm_check
  import dtb_chk_pkg::*;
#(
  parameter int MODES = 4
) (
  input  logic                     write,
  input  logic [$clog2(MODES)-1:0] mode,
  input  logic                     hit,
  input  logic                     pte_fetch,
  input  logic [MODES-1:0]         rd_en,
  input  logic [MODES-1:0]         wr_en,
  input  logic                     fault_rd,
  input  logic                     fault_wr,
  output verdict_t                 verdict
);
  logic allowed;

  always_comb begin
    allowed = write ? wr_en[mode] : rd_en[mode];
    verdict.code = FLT_NONE;
    verdict.stat = '0;
    if (!hit) begin
      verdict.code          = pte_fetch ? FLT_PTE_MISS : FLT_MISS;
      verdict.stat[ST_MISS] = 1'b1;
      verdict.stat[ST_WR]   = write;
    end else if (write) begin
      if (!allowed) begin
        verdict.code         = FLT_GENERAL;
        verdict.stat[ST_WR]  = 1'b1;
        verdict.stat[ST_ACV] = 1'b1;
        verdict.stat[ST_FOW] = fault_wr;
      end else if (fault_wr) begin
        verdict.code         = FLT_GENERAL;
        verdict.stat[ST_WR]  = 1'b1;
        verdict.stat[ST_FOW] = 1'b1;
      end
    end else begin
      if (!allowed) begin
        verdict.code         = FLT_ACCESS;
        verdict.stat[ST_ACV] = 1'b1;
        verdict.stat[ST_FOR] = fault_rd;
      end else if (fault_rd) begin
        verdict.code         = FLT_GENERAL;
        verdict.stat[ST_FOR] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dtb_fault_capture.sv
module dtb_fault_capture
  import dtb_chk_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 13,
  parameter int VPN_HI    = 42,
  parameter int FORM_SH   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [VA_W-1:0]   va,
  input  logic [STAT_W-1:0] stat,
  input  logic [VA_W-1:0]   ptbase,
  output logic [VA_W-1:0]   cap_va,
  output logic [STAT_W-1:0] cap_stat,
  output logic [VA_W-1:0]   cap_form
);
  localparam int VPN_W = VPN_HI - PAGE_BITS + 1;

  logic [VA_W-1:0] form_next;

  always_comb begin
    form_next = ptbase | (VA_W'(va[VPN_HI:PAGE_BITS]) << FORM_SH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_va   <= '0;
      cap_stat <= '0;
      cap_form <= '0;
    end else if (fire) begin
      cap_va   <= va;
      cap_stat <= stat;
      cap_form <= form_next;
    end
  end

  logic unused_w;
  assign unused_w = ^VPN_W;
endmodule

// File: rtl/dtb_access_check.sv
module dtb_access_check
  import dtb_chk_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int VA_IMPL   = 48,
  parameter int PA_W      = 44,
  parameter int PAGE_BITS = 13,
  parameter int VPN_HI    = 42,
  parameter int MODES     = 4,
  parameter int MODE_W    = $clog2(MODES),
  parameter int PFN_W     = PA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_write,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_pte_fetch,
  input  logic              req_no_fault,
  input  logic              req_spec,
  input  logic              lk_hit,
  input  logic [MODES-1:0]  lk_rd_en,
  input  logic [MODES-1:0]  lk_wr_en,
  input  logic              lk_fault_rd,
  input  logic              lk_fault_wr,
  input  logic [PFN_W-1:0]  lk_pfn,
  input  logic [VA_W-1:0]   ptbase,
  output logic              rsp_valid,
  output logic [2:0]        rsp_fault,
  output logic [STAT_W-1:0] rsp_stat,
  output logic [PA_W-1:0]   rsp_pa,
  output logic [VA_W-1:0]   cap_va,
  output logic [STAT_W-1:0] cap_stat,
  output logic [VA_W-1:0]   cap_form
);
  localparam logic [MODE_W-1:0] KERNEL = '0;

  logic            va_ok;
  logic            is_sp;
  logic [PA_W-1:0] sp_pa;
  verdict_t        perm_v;
  verdict_t        final_v;
  logic [PA_W-1:0] pa_next;
  logic            capture;

  dtb_va_classify #(
    .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W)
  ) u_class (
    .va(req_va), .va_ok(va_ok), .is_sp(is_sp), .sp_pa(sp_pa)
  );

  dtb_perm_check #(.MODES(MODES)) u_perm (
    .write(req_write), .mode(req_mode), .hit(lk_hit),
    .pte_fetch(req_pte_fetch), .rd_en(lk_rd_en), .wr_en(lk_wr_en),
    .fault_rd(lk_fault_rd), .fault_wr(lk_fault_wr), .verdict(perm_v)
  );

  always_comb begin
    final_v.code = FLT_NONE;
    final_v.stat = '0;
    pa_next      = '0;
    if (!va_ok) begin
      final_v.code          = FLT_GENERAL;
      final_v.stat[ST_BAD]  = 1'b1;
      final_v.stat[ST_ACV]  = 1'b1;
      final_v.stat[ST_WR]   = req_write;
    end else if (is_sp) begin
      if (req_mode != KERNEL) begin
        final_v.code         = FLT_ACCESS;
        final_v.stat[ST_ACV] = 1'b1;
        final_v.stat[ST_WR]  = req_write;
      end else begin
        pa_next = sp_pa;
      end
    end else begin
      final_v = perm_v;
      if (perm_v.code == FLT_NONE) pa_next = {lk_pfn, req_va[PAGE_BITS-1:0]};
    end
    capture = req_valid && (final_v.code != FLT_NONE) &&
              !req_pte_fetch && !req_no_fault && !req_spec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= '0;
      rsp_stat  <= '0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= final_v.code;
        rsp_stat  <= final_v.stat;
        rsp_pa    <= pa_next;
      end
    end
  end

  dtb_fault_capture #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .VPN_HI(VPN_HI)
  ) u_cap (
    .clk(clk), .rst(rst), .fire(capture), .va(req_va), .stat(final_v.stat),
    .ptbase(ptbase), .cap_va(cap_va), .cap_stat(cap_stat), .cap_form(cap_form)
  );
endmodule

// File: rtl/dtb_access_check_sva.sv
module dtb_access_check_sva (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [63:0] req_va,
  input logic        req_write,
  input logic [1:0]  req_mode,
  input logic        req_pte_fetch,
  input logic        req_no_fault,
  input logic        req_spec,
  input logic        rsp_valid,
  input logic [2:0]  rsp_fault,
  input logic [5:0]  rsp_stat,
  input logic [63:0] cap_va,
  input logic [5:0]  cap_stat
);
  logic sp_user;
  assign sp_user = req_valid && (&req_va[63:47]) &&
                   (req_va[47:41] == 7'h7E) && (req_mode != 2'd0);

  p_follow_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (rsp_valid == $past(req_valid)));

  p_clean_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == 3'd0) |-> (rsp_stat == 6'd0));

  p_fault_stat_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_stat != 6'd0));

  p_miss_bit_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_fault == 3'd3 || rsp_fault == 3'd4)) |->
    (rsp_stat[4] && !rsp_stat[1]));

  p_load_nowr_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && !req_write) |-> !rsp_stat[0]);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && req_valid && (req_pte_fetch || req_no_fault || req_spec))
    |-> ($stable(cap_va) && $stable(cap_stat)));

  p_sp_user_r3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && sp_user) |-> (rsp_fault == 3'd1));
endmodule

bind dtb_access_check dtb_access_check_sva u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_va(req_va),
  .req_write(req_write), .req_mode(req_mode), .req_pte_fetch(req_pte_fetch),
  .req_no_fault(req_no_fault), .req_spec(req_spec), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_stat(rsp_stat), .cap_va(cap_va),
  .cap_stat(cap_stat)
);

// File: tb/dtb_access_check_tb_top.sv
module dtb_access_check_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [63:0] req_va = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_mode = '0;
  logic        req_pte_fetch = 1'b0;
  logic        req_no_fault = 1'b0;
  logic        req_spec = 1'b0;
  logic        lk_hit = 1'b0;
  logic [3:0]  lk_rd_en = '0;
  logic [3:0]  lk_wr_en = '0;
  logic        lk_fault_rd = 1'b0;
  logic        lk_fault_wr = 1'b0;
  logic [30:0] lk_pfn = '0;
  logic [63:0] ptbase = 64'h0000_0200_0000_0000;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [5:0]  rsp_stat;
  logic [43:0] rsp_pa;
  logic [63:0] cap_va;
  logic [5:0]  cap_stat;
  logic [63:0] cap_form;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] e_cva = '0;
  logic [5:0]  e_cst = '0;
  logic [63:0] e_cfm = '0;

  always #2.5 clk = ~clk;

  dtb_access_check dut_i (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h va=%h", tag, act, exp, req_va);
    end
  endtask

  task automatic model(output logic [2:0] f, output logic [5:0] st, output logic [43:0] pa);
    logic [16:0] top;
    logic en;
    top = req_va[63:47];
    f = 0; st = 0; pa = 0;
    if (!(top == 17'h0 || top == 17'h1FFFF)) begin
      f = 2; st = 6'b100010 | {5'b0, req_write};
    end else if (req_va[47:41] == 7'h7E) begin
      if (req_mode != 0) begin f = 1; st = 6'b000010 | {5'b0, req_write}; end
      else pa = {{4{req_va[40]}}, req_va[39:0]};
    end else if (!lk_hit) begin
      st = 6'b010000 | {5'b0, req_write}; f = req_pte_fetch ? 3'd4 : 3'd3;
    end else if (req_write) begin
      en = lk_wr_en[req_mode];
      if (!en) begin f = 2; st = 6'b000011 | (lk_fault_wr ? 6'b001000 : 6'b0); end
      else if (lk_fault_wr) begin f = 2; st = 6'b001001; end
      else pa = {lk_pfn, req_va[12:0]};
    end else begin
      en = lk_rd_en[req_mode];
      if (!en) begin f = 1; st = 6'b000010 | (lk_fault_rd ? 6'b000100 : 6'b0); end
      else if (lk_fault_rd) begin f = 2; st = 6'b000100; end
      else pa = {lk_pfn, req_va[12:0]};
    end
  endtask

  // Drives the current inputs as one request, checks response and capture.
  task automatic run(input string tag);
    logic [2:0] f; logic [5:0] st; logic [43:0] pa;
    model(f, st, pa);
    if (f != 0 && !req_pte_fetch && !req_no_fault && !req_spec) begin
      e_cva = req_va; e_cst = st;
      e_cfm = ptbase | ({34'b0, req_va[42:13]} << 3);
    end
    req_valid = 1'b1;
    @(negedge clk);
    chk({tag, " valid R11"}, {63'b0, rsp_valid}, 64'd1);
    chk({tag, " fault"}, {61'b0, rsp_fault}, {61'b0, f});
    chk({tag, " stat"}, {58'b0, rsp_stat}, {58'b0, st});
    chk({tag, " pa R8"}, {20'b0, rsp_pa}, {20'b0, pa});
    chk("R9 cap_va", cap_va, e_cva);
    chk("R9 cap_stat", {58'b0, cap_stat}, {58'b0, e_cst});
    chk("R9 cap_form", cap_form, e_cfm);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 rsp_valid", {63'b0, rsp_valid}, 0);
    chk("R1 rsp_fault", {61'b0, rsp_fault}, 0);
    chk("R1 rsp_stat", {58'b0, rsp_stat}, 0);
    chk("R1 rsp_pa", {20'b0, rsp_pa}, 0);
    chk("R1 cap_va", cap_va, 0);
    chk("R1 cap_stat", {58'b0, cap_stat}, 0);
    chk("R1 cap_form", cap_form, 0);

    // R2: non-canonical addresses in every mode, both directions
    for (int k = 0; k < 4; k++) begin
      for (int m = 0; m < 4; m++) begin
        for (int w = 0; w < 2; w++) begin
          case (k)
            0: req_va = 64'h0001_0000_0000_0000;
            1: req_va = 64'h8000_0000_0000_1234;
            2: req_va = 64'hFFFF_7FFF_FFFF_E000;
            default: req_va = 64'h7FFF_FC00_0000_0000;
          endcase
          req_mode = 2'(m); req_write = w[0]; lk_hit = 1'b1;
          lk_rd_en = 4'hF; lk_wr_en = 4'hF;
          run("R2 badva");
        end
      end
    end

    // R3/R4: superpage window, both values of bit 40
    for (int k = 0; k < 8; k++) begin
      for (int m = 0; m < 4; m++) begin
        for (int w = 0; w < 2; w++) begin
          req_va = {16'hFFFF, 7'h7E, k[0], 40'h12_3456_789A ^ {k[2:1], 38'h0}};
          req_mode = 2'(m); req_write = w[0]; lk_hit = 1'b0;
          run(m == 0 ? "R4 superpage" : "R3 superpage user");
        end
      end
    end

    // R5-R8: lookup sweep over mode, direction, enables, fault bits, hit, fetch
    for (int m = 0; m < 4; m++) begin
      for (int w = 0; w < 2; w++) begin
        for (int re = 0; re < 16; re++) begin
          for (int we = 0; we < 16; we++) begin
            for (int fb = 0; fb < 16; fb++) begin
              req_va = {16'h0, 5'h0, 12'(re * 16 + we), 4'(fb), 14'(m * 977), 13'(fb * 311)};
              req_mode = 2'(m); req_write = w[0];
              lk_rd_en = 4'(re); lk_wr_en = 4'(we);
              lk_fault_rd = fb[0]; lk_fault_wr = fb[1];
              lk_hit = fb[2]; req_pte_fetch = fb[3];
              lk_pfn = 31'(re * 7919 + we * 131 + fb);
              run(w[0] ? "R6 store" : "R7 load");
            end
          end
        end
      end
    end
    req_pte_fetch = 1'b0;

    // R10: suppression combinations on a faulting miss; R5 fetch miss code
    for (int s = 0; s < 8; s++) begin
      req_va = 64'h0000_0045_6780_0000 + 64'(s) * 64'h2000;
      req_mode = 2'd1; req_write = s[0]; lk_hit = 1'b0;
      req_pte_fetch = s[0]; req_no_fault = s[1]; req_spec = s[2];
      run("R10 suppress");
    end
    req_pte_fetch = 1'b0; req_no_fault = 1'b0; req_spec = 1'b0;

    // R10: clean access leaves capture intact
    lk_hit = 1'b1; lk_rd_en = 4'hF; lk_fault_rd = 1'b0; req_write = 1'b0;
    req_va = 64'h0000_0000_0000_4000;
    run("R10 clean");

    // R11: idle cycle gives no response
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11 idle", {63'b0, rsp_valid}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule